// File: doc/BRIEF.md
# Presettable Cascadable Binary Counter

This block is a small synchronous up-counter, four bits wide by default, whose flops all update together on the rising clock edge. It has three controls, all active low or active high as marked:

- An active-low preset copies a parallel data word into the count.
- An active-low clear forces the count to zero.
- Two active-high count enables must both be high for the count to advance. One is the parallel enable and the other is the trickle enable.

A terminal-count carry output lets several instances be chained into a wider counter.

A build-time parameter selects when clear takes effect. In the synchronous variant, clear acts on a clock edge. In the asynchronous variant, clear acts at once, without waiting for the clock. Its release is then passed through a short flop chain, so the count leaves zero only on a clean edge.

To chain instances, connect the carry of each stage to the trickle enable of the next stage. The parallel enable, clock, clear and preset are shared by all stages. Clear has priority over preset, and preset has priority over counting.

Top module: `presettable_counter`

## Requirements
- R1: With clear and preset inactive and both enables high, the count rises by one on every rising clock edge, and it wraps from all ones (4'b1111) to zero.
- R2: When the preset input is low at a rising edge, the data input is copied into the count whatever the enables are. When the preset input is high, the data input has no effect.
- R3: In synchronous-clear mode (ASYNC_CLR=0), the count becomes zero on a rising edge at which clear is low, and not before that edge.
- R4: In asynchronous-clear mode (ASYNC_CLR=1), the count becomes zero as soon as clear goes low, with no clock edge. After clear returns high, the count stays zero through the next two rising edges and then behaves normally.
- R5: With clear and preset inactive, the count holds its value whenever either enable is low.
- R6: The carry output is high exactly when the count is all ones and the trickle enable is high. The parallel enable has no influence on it.
- R7: The priority order is clear over preset over counting. Clear wins over a simultaneous preset, and a preset wins over active enables.
- R8: Three chained stages, each stage's carry feeding the next stage's trickle enable, count as one 12-bit counter through every wrap. The last stage's carry is high at 12'hFFF while the first stage's trickle enable is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| clr_n | input | 1 | Active-low clear, synchronous or asynchronous per ASYNC_CLR |
| load_n | input | 1 | Active-low parallel preset |
| en_p | input | 1 | Parallel count enable, active high |
| en_t | input | 1 | Trickle count enable, active high; also gates the carry |
| d | input | WIDTH | Preset data |
| q | output | WIDTH | Current count |
| rco | output | 1 | Terminal-count carry |

## Verification
The bench aims at the places where the ordering of controls is easy to get wrong:

- A preset and a clear arrive together, so that a design with load and clear swapped in priority would show the preset word.
- A preset arrives while the enables are high, so that a design which lets counting win would show an increment.
- The count sits at all ones with only one enable low. A carry gated by the wrong enable would then show up directly on the carry output.
- The asynchronous clear is dropped in the middle of a cycle and checked before the next edge. A synchronous-only implementation would still show the old count, and a missing release chain would resume counting two edges early.
- The three-stage chain is run through its full range, so that a carry miswired to the parallel enable breaks the upper nibbles at the first wrap.

// File: rtl/cnt_pkg.sv
`timescale 1ns/1ps
// Package: shared operation encoding for the presettable counter.
// Assumes the decoded operation is one of four mutually exclusive actions.
package cnt_pkg;

    typedef enum logic [1:0] {
        OP_HOLD  = 2'd0,
        OP_COUNT = 2'd1,
        OP_LOAD  = 2'd2,
        OP_CLEAR = 2'd3
    } cnt_op_e;

endpackage

// File: rtl/cnt_op_decode.sv
`timescale 1ns/1ps
// Module: cnt_op_decode
// Turns the clear, preset and enable controls into one operation for the
// next edge. The order is fixed: clear, then preset, then count, then hold.
// Assumes clr_act is already active high and qualified by the clear mode.
module cnt_op_decode
    import cnt_pkg::*;
(
    input  logic    clr_act,
    input  logic    load_n,
    input  logic    en_p,
    input  logic    en_t,
    output cnt_op_e op
);

    // Purpose: fixed-priority selection of the next action.
    always_comb begin
        if (clr_act)
            op = OP_CLEAR;
        else if (!load_n)
            op = OP_LOAD;
        else if (en_p && en_t)
            op = OP_COUNT;
        else
            op = OP_HOLD;
    end

endmodule

// File: rtl/cnt_release_sync.sv
`timescale 1ns/1ps
// Module: cnt_release_sync
// Release synchroniser for the asynchronous clear. The chain of flops is
// reset at once when clr_n falls, and it fills with ones on the clock after
// clr_n rises. released goes high STAGES edges after the release.
// Assumes STAGES >= 1.
module cnt_release_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic clr_n,
    output logic released
);

    logic [STAGES-1:0] chain_q;

    // Purpose: clear the chain at once, then shift in ones on the clock.
    always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n) begin
            chain_q <= '0;
        end else begin
            chain_q[0] <= 1'b1;
            for (int i = 1; i < STAGES; i++) begin
                chain_q[i] <= chain_q[i-1];
            end
        end
    end

    assign released = chain_q[STAGES-1];

endmodule

// File: rtl/cnt_state.sv
`timescale 1ns/1ps
// Module: cnt_state
// The count register. It applies the decoded operation on each rising edge.
// arst_n clears the register immediately. The top ties it high when the
// clear mode is synchronous.
module cnt_state
    import cnt_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             arst_n,
    input  cnt_op_e          op,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    // Purpose: update the count according to the selected operation.
    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            q <= '0;
        end else begin
            unique case (op)
                OP_CLEAR: q <= '0;
                OP_LOAD:  q <= d;
                OP_COUNT: q <= q + 1'b1;
                default:  q <= q;
            endcase
        end
    end

endmodule

// File: rtl/cnt_carry.sv
`timescale 1ns/1ps
// Module: cnt_carry
// Combinational terminal-count detector. The carry is high when every count
// bit is one and the trickle enable is high.
// Assumes the next stage treats rco as its trickle enable.
module cnt_carry #(
    parameter int WIDTH = 4
) (
    input  logic [WIDTH-1:0] q,
    input  logic             en_t,
    output logic             rco
);

    // Purpose: AND-reduce the count and gate the result with the trickle enable.
    always_comb begin
        rco = en_t & (&q);
    end

endmodule

// File: rtl/presettable_counter.sv
`timescale 1ns/1ps
// Module: presettable_counter
// Presettable binary up-counter built for chaining. ASYNC_CLR picks the
// clear mode:
//   0: clear acts on the clock edge.
//   1: clear acts at once, and its release is synchronised over
//      REL_STAGES flops.
// Assumes the parallel enable and the clock are shared when stages are chained.
module presettable_counter
    import cnt_pkg::*;
#(
    parameter int WIDTH      = 4,
    parameter bit ASYNC_CLR  = 1'b0,
    parameter int REL_STAGES = 2
) (
    input  logic             clk,
    input  logic             clr_n,
    input  logic             load_n,
    input  logic             en_p,
    input  logic             en_t,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q,
    output logic             rco
);

    localparam logic [WIDTH-1:0] ALL_ONES = {WIDTH{1'b1}};

    logic    released;
    logic    clr_act;
    logic    arst_n;
    cnt_op_e op;

    generate
        if (ASYNC_CLR) begin : g_async
            cnt_release_sync #(.STAGES(REL_STAGES)) rel_i (
                .clk      (clk),
                .clr_n    (clr_n),
                .released (released)
            );
            assign arst_n  = clr_n;
            assign clr_act = !released;

            // R4: the count is already zero at any edge while clear is low.
            p_async_clear_r4: assert property (@(posedge clk)
                !clr_n |-> q == '0);
            // R4: the count stays zero while the release chain is still filling.
            p_release_hold_r4: assert property (@(posedge clk) disable iff (!clr_n)
                !released |=> q == '0);
        end else begin : g_sync
            assign released = 1'b1;
            assign arst_n   = 1'b1;
            assign clr_act  = !clr_n;

            // R3: clear low at an edge gives zero after that edge.
            p_sync_clear_r3: assert property (@(posedge clk)
                !clr_n |=> q == '0);
        end
    endgenerate

    cnt_op_decode dec_i (
        .clr_act (clr_act),
        .load_n  (load_n),
        .en_p    (en_p),
        .en_t    (en_t),
        .op      (op)
    );

    cnt_state #(.WIDTH(WIDTH)) state_i (
        .clk    (clk),
        .arst_n (arst_n),
        .op     (op),
        .d      (d),
        .q      (q)
    );

    cnt_carry #(.WIDTH(WIDTH)) carry_i (
        .q    (q),
        .en_t (en_t),
        .rco  (rco)
    );

    // R2: a preset copies the data word into the count.
    p_load_r2: assert property (@(posedge clk) disable iff (!clr_n)
        (released && !load_n) |=> q == $past(d));

    // R1: a count step adds one to the count.
    p_count_r1: assert property (@(posedge clk) disable iff (!clr_n)
        (released && load_n && en_p && en_t) |=> q == WIDTH'($past(q) + 1'b1));

    // R1: from all ones the count wraps to zero.
    p_wrap_r1: assert property (@(posedge clk) disable iff (!clr_n)
        (released && load_n && en_p && en_t && q == ALL_ONES) |=> q == '0);

    // R5: with either enable low, the count holds.
    p_hold_r5: assert property (@(posedge clk) disable iff (!clr_n)
        (released && load_n && !(en_p && en_t)) |=> $stable(q));

    // R6: the carry is low whenever the trickle enable is low.
    p_carry_gate_r6: assert property (@(posedge clk) disable iff (!clr_n)
        !en_t |-> !rco);

    // R6: the carry is high only at terminal count.
    p_carry_tc_r6: assert property (@(posedge clk) disable iff (!clr_n)
        rco |-> q == ALL_ONES);

endmodule

// File: tb/presettable_counter_tb_top.sv
`timescale 1ns/1ps
// Scoreboard bench. A driver task applies the stimulus and queues the
// expected state for the next edge. A monitor pops each item and compares
// it 3 ns after that edge.
module presettable_counter_tb_top;

    logic        clk = 1'b0;
    logic        clr_n = 1'b0;
    logic        load_n = 1'b1;
    logic        ep = 1'b0;
    logic        et = 1'b0;
    logic [3:0]  d = 4'h0;
    logic [11:0] dc = 12'h000;

    logic [3:0]  q_s, q_a;
    logic        rco_s, rco_a;
    logic [11:0] q_c;
    logic        rco0, rco1, rco_c;

    int errors = 0;
    int checks = 0;
    int cyc = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    presettable_counter #(.WIDTH(4), .ASYNC_CLR(1'b0)) dut_i (
        .clk(clk), .clr_n(clr_n), .load_n(load_n), .en_p(ep), .en_t(et),
        .d(d), .q(q_s), .rco(rco_s));

    presettable_counter #(.WIDTH(4), .ASYNC_CLR(1'b1)) dut_a (
        .clk(clk), .clr_n(clr_n), .load_n(load_n), .en_p(ep), .en_t(et),
        .d(d), .q(q_a), .rco(rco_a));

    presettable_counter #(.WIDTH(4)) stg0 (
        .clk(clk), .clr_n(clr_n), .load_n(load_n), .en_p(ep), .en_t(et),
        .d(dc[3:0]), .q(q_c[3:0]), .rco(rco0));
    presettable_counter #(.WIDTH(4)) stg1 (
        .clk(clk), .clr_n(clr_n), .load_n(load_n), .en_p(ep), .en_t(rco0),
        .d(dc[7:4]), .q(q_c[7:4]), .rco(rco1));
    presettable_counter #(.WIDTH(4)) stg2 (
        .clk(clk), .clr_n(clr_n), .load_n(load_n), .en_p(ep), .en_t(rco1),
        .d(dc[11:8]), .q(q_c[11:8]), .rco(rco_c));

    typedef struct {
        int          due;
        string       tag;
        logic [3:0]  es;
        logic        ers;
        logic [3:0]  ea;
        logic        era;
        logic [11:0] ec;
        logic        erc;
    } item_t;

    item_t sb[$];

    logic [3:0]  m_s = 4'h0;
    logic [3:0]  m_a = 4'h0;
    int          rel = 2;
    logic [11:0] m_c = 12'h000;

    task automatic chk(input string tag, input string what, input int got, input int exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h at cycle %0d", tag, what, got, exp, cyc);
        end
    endtask

    // Apply one cycle of stimulus and queue the expected post-edge state.
    task automatic step(input logic c, input logic ld, input logic p, input logic t,
                        input logic [3:0] dv, input logic [11:0] dcv, input string tag);
        item_t it;
        logic was_high;
        @(posedge clk);
        #5;
        was_high = clr_n;
        clr_n = c; load_n = ld; ep = p; et = t; d = dv; dc = dcv;
        if (was_high && !c) begin
            #2;
            chk("R4", "async q immediate", q_a, 0);
            chk("R3", "sync q before edge", q_s, m_s);
        end
        if (!c) m_s = 4'h0;
        else if (!ld) m_s = dv;
        else if (p && t) m_s = m_s + 4'h1;
        if (!c) begin m_a = 4'h0; rel = 2; end
        else if (rel > 0) begin rel--; m_a = 4'h0; end
        else if (!ld) m_a = dv;
        else if (p && t) m_a = m_a + 4'h1;
        if (!c) m_c = 12'h000;
        else if (!ld) m_c = dcv;
        else if (p && t) m_c = m_c + 12'h001;
        it.due = cyc + 1;
        it.tag = tag;
        it.es = m_s; it.ers = (m_s == 4'hF) && t;
        it.ea = m_a; it.era = (m_a == 4'hF) && t;
        it.ec = m_c; it.erc = (m_c == 12'hFFF) && t;
        sb.push_back(it);
    endtask

    // Monitor: compare the queued expectations 3 ns after each edge.
    initial begin
        forever begin
            @(posedge clk);
            #3;
            while (sb.size() > 0 && sb[0].due <= cyc) begin
                item_t it;
                it = sb.pop_front();
                if (it.due == cyc) begin
                    chk(it.tag, "sync q", q_s, it.es);
                    chk(it.tag, "sync rco", rco_s, it.ers);
                    chk(it.tag, "async q", q_a, it.ea);
                    chk(it.tag, "async rco", rco_a, it.era);
                    chk(it.tag, "chain q", q_c, it.ec);
                    chk(it.tag, "chain rco", rco_c, it.erc);
                end
            end
        end
    end

    initial begin
        // R3 and R4: clear from time zero.
        for (int i = 0; i < 3; i++) step(0, 1, 0, 0, 4'h0, 12'h000, "R3");
        // R1: free count through several wraps; async lags two edges.
        for (int i = 0; i < 36; i++) step(1, 1, 1, 1, 4'h5, 12'h0A5, "R1");
        // R5: parallel enable low, then trickle enable low.
        for (int i = 0; i < 4; i++) step(1, 1, 0, 1, 4'h3, 12'h333, "R5");
        for (int i = 0; i < 4; i++) step(1, 1, 1, 0, 4'h3, 12'h333, "R5");
        // R2: preset with both enables low.
        step(1, 0, 0, 0, 4'hF, 12'hFFF, "R2");
        // R6: at all ones, the trickle enable alone gates the carry.
        step(1, 1, 1, 0, 4'h0, 12'h000, "R6");
        step(1, 1, 0, 1, 4'h0, 12'h000, "R6");
        step(1, 1, 0, 0, 4'h0, 12'h000, "R6");
        // R7: clear beats a simultaneous preset.
        step(0, 0, 1, 1, 4'hA, 12'hAAA, "R7");
        step(1, 1, 0, 0, 4'h0, 12'h000, "R7");
        step(1, 1, 0, 0, 4'h0, 12'h000, "R7");
        // R7: preset beats active enables.
        step(1, 0, 1, 1, 4'h9, 12'h9C9, "R7");
        step(1, 1, 1, 1, 4'h0, 12'h000, "R1");
        // R4: clear pulse between edges, then release and resume.
        step(0, 1, 1, 1, 4'h0, 12'h000, "R4");
        for (int i = 0; i < 5; i++) step(1, 1, 1, 1, 4'h0, 12'h000, "R4");
        // R8: preset near the nibble carries, then run the chain past full wrap.
        step(1, 0, 0, 0, 4'h0, 12'h0F0, "R8");
        for (int i = 0; i < 20; i++) step(1, 1, 1, 1, 4'h0, 12'h000, "R8");
        step(1, 0, 0, 0, 4'h0, 12'hFF8, "R8");
        for (int i = 0; i < 12; i++) step(1, 1, 1, 1, 4'h0, 12'h000, "R8");
        step(0, 1, 0, 0, 4'h0, 12'h000, "R8");
        for (int i = 0; i < 4200; i++) step(1, 1, 1, 1, 4'h0, 12'h000, "R8");
        step(1, 1, 0, 0, 4'h0, 12'h000, "R5");
        @(posedge clk);
        @(posedge clk);
        #5;
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #2_000_000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule